// File: doc/BRIEF.md
# Cumulative Row Boundary Address Decoder

This block turns a physical memory address into the chip-select row that holds it. Eight boundary registers each hold the running total of installed memory up to and including their row, in 64 MiB blocks. No per-row size is stored. A row spans from the boundary of the row below it, inclusive, up to its own boundary, exclusive. Row 0 starts at address zero. A row whose boundary equals the one below it holds no memory and can never be selected.

Configuration software writes the boundaries one byte at a time through a small write port. The low seven bits of each byte are kept and the top bit is reserved. A mode input selects single-channel operation, where all eight rows are used, or dual-channel operation. In dual-channel mode only the lower four rows exist, and each holds memory split evenly over both channels. Lookups are qualified by a valid strobe. One clock later the block returns the row index, a hit flag and an out-of-range flag.

Top module: `row_bound_decoder`

## Requirements
- R1: Synchronous active-low reset clears all boundary registers to zero and drives rsp_valid, rsp_hit, rsp_oor and rsp_row to zero. The first lookup after reset then reports out of range for every address.
- R2: A cycle with cfg_we high loads bits 6:0 of cfg_wdata into the boundary register selected by cfg_sel. Bit 7 of cfg_wdata is discarded.
- R3: Let the block number be req_addr[32:26]. The lookup hits row i when the block number is at least the boundary of row i-1 (zero for row 0) and below the boundary of row i. The response then carries rsp_hit=1 and rsp_row=i.
- R4: A row whose boundary equals that of the row below it is never returned as the matching row.
- R5: When the block number is at or above the boundary of the last active row (row 7 in single-channel mode, row 3 in dual-channel mode), the response carries rsp_oor=1, rsp_hit=0 and rsp_row=0.
- R6: When the ranges of several rows contain the address (possible only with non-increasing boundaries), the lowest-numbered row is returned.
- R7: With dual_mode=1, rows 4 to 7 are never matched and do not affect the out-of-range limit, whatever they hold.
- R8: A lookup presented with req_valid=1 on one clock edge produces its response with rsp_valid=1 after that edge. A cycle with req_valid=0 gives rsp_valid=0 after the next edge, and rsp_row, rsp_hit and rsp_oor keep their values.
- R9: Address bits 25:0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_sel | input | 3 | Index of the boundary register to write |
| cfg_wdata | input | 8 | Write byte; bits 6:0 boundary in 64 MiB blocks, bit 7 reserved |
| dual_mode | input | 1 | 0 = single channel (8 rows), 1 = dual channel (4 rows) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 33 | Physical byte address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_row | output | 3 | Matching row index (0 when there is no hit) |
| rsp_hit | output | 1 | Address lies in a populated active row |
| rsp_oor | output | 1 | Address at or above the installed memory total |

## Verification
A bound checker keeps its own copy of the boundaries, built only from the write port, and a snapshot taken at each lookup. On every response it checks the following: a reported row actually contains the address and is populated, the out-of-range flag agrees with the active total, hit and out-of-range never appear together, dual-channel mode never reports an upper row, and the response timing and hold behaviour are correct. The bench sweeps every block number with two extreme low-bit patterns over a monotonic map with empty rows, the same map in dual-channel mode, and an overlapping map. Only these sweeps show that the right row wins under overlap (lowest index) and that no address is missed, since the checker accepts a miss that is not out of range.

// File: rtl/rbd_pkg.sv
// Package rbd_pkg
// Shared types for the row boundary decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package rbd_pkg;

    typedef enum logic {
        CH_SINGLE = 1'b0,
        CH_DUAL   = 1'b1
    } chan_mode_e;

    typedef struct packed {
        logic hit;
        logic oor;
    } lookup_flags_t;

endpackage

// File: rtl/rbd_bound_regs.sv
// Module rbd_bound_regs
// Holds one boundary register per row, loaded one at a time via a byte port.
// Assumes: the write byte is BND_W+1 bits wide and its top bit is reserved.
module rbd_bound_regs #(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          sel,
    input  logic [BND_W:0]            wdata,
    output logic [NUM_ROWS*BND_W-1:0] bnd_flat
);

    logic unused_rsvd_bit;
    assign unused_rsvd_bit = wdata[BND_W];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        logic [BND_W-1:0] bnd_q;

        // Purpose: load this row's boundary when it is selected for write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bnd_q <= '0;
            end else if (we && (sel == IDX_W'(g))) begin
                bnd_q <= wdata[BND_W-1:0];
            end
        end

        assign bnd_flat[g*BND_W +: BND_W] = bnd_q;
    end

endmodule

// File: rtl/rbd_row_match.sv
// Module rbd_row_match
// Compares a block number against each row's [lower, upper) window.
// It also selects the installed-memory total for the current channel mode.
// Assumes: the lower bound of row 0 is zero; in dual mode only the lower half of the rows is active.
module rbd_row_match #(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7
) (
    input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
    input  logic [BND_W-1:0]          blk,
    input  logic                      dual,
    output logic [NUM_ROWS-1:0]       match,
    output logic [BND_W-1:0]          total
);

    localparam int HALF = NUM_ROWS / 2;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
        localparam bit LOWER_HALF = (g < HALF);
        logic [BND_W-1:0] lo;
        logic [BND_W-1:0] hi;

        if (g == 0) begin : g_first
            assign lo = '0;
        end else begin : g_rest
            assign lo = bnd_flat[(g-1)*BND_W +: BND_W];
        end
        assign hi = bnd_flat[g*BND_W +: BND_W];

        // Purpose: flag the row when it is active and the block falls in its window.
        always_comb begin
            match[g] = (LOWER_HALF || !dual) && (blk >= lo) && (blk < hi);
        end
    end

    // Purpose: pick the top active row's boundary as the memory total.
    always_comb begin
        if (dual) begin
            total = bnd_flat[(HALF-1)*BND_W +: BND_W];
        end else begin
            total = bnd_flat[(NUM_ROWS-1)*BND_W +: BND_W];
        end
    end

endmodule

// File: rtl/rbd_prio.sv
// Module rbd_prio
// Lowest-index-first priority encoder over the row match vector.
// Assumes: IDX_W is wide enough to hold NUM_ROWS-1.
module rbd_prio #(
    parameter int NUM_ROWS = 8,
    parameter int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic [NUM_ROWS-1:0] match,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);

    // Purpose: scan from the top so the lowest set index is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/row_bound_decoder.sv
// Module row_bound_decoder
// Maps a physical address to the chip-select row whose cumulative boundary
// window contains it. The result is registered one cycle after req_valid.
// Assumes: boundaries count GRAIN_SHIFT-sized blocks; an address at or above
// the top active boundary is out of range and never a hit.
module row_bound_decoder
    import rbd_pkg::*;
#(
    parameter int NUM_ROWS    = 8,
    parameter int BND_W       = 7,
    parameter int GRAIN_SHIFT = 26,
    parameter int ADDR_W      = BND_W + GRAIN_SHIFT,
    parameter int IDX_W       = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [BND_W:0]    cfg_wdata,
    input  logic              dual_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_row,
    output logic              rsp_hit,
    output logic              rsp_oor
);

    logic [NUM_ROWS*BND_W-1:0] bnd_flat;
    logic [NUM_ROWS-1:0]       match;
    logic [BND_W-1:0]          blk;
    logic [BND_W-1:0]          total;
    logic                      any_match;
    logic [IDX_W-1:0]          win_idx;
    chan_mode_e                mode;
    lookup_flags_t             flags;
    logic                      unused_low_bits;

    assign mode            = chan_mode_e'(dual_mode);
    assign blk             = req_addr[ADDR_W-1:GRAIN_SHIFT];
    assign unused_low_bits = ^req_addr[GRAIN_SHIFT-1:0];

    rbd_bound_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .bnd_flat (bnd_flat)
    );

    rbd_row_match #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W)
    ) u_match (
        .bnd_flat (bnd_flat),
        .blk      (blk),
        .dual     (mode == CH_DUAL),
        .match    (match),
        .total    (total)
    );

    rbd_prio #(
        .NUM_ROWS (NUM_ROWS),
        .IDX_W    (IDX_W)
    ) u_prio (
        .match (match),
        .any   (any_match),
        .idx   (win_idx)
    );

    // Purpose: out of range overrides any row match.
    always_comb begin
        flags.oor = (blk >= total);
        flags.hit = any_match && !flags.oor;
    end

    // Purpose: register the lookup result; hold it while no request is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_row   <= '0;
            rsp_hit   <= 1'b0;
            rsp_oor   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_row <= flags.hit ? win_idx : '0;
                rsp_hit <= flags.hit;
                rsp_oor <= flags.oor;
            end
        end
    end

endmodule

// File: rtl/row_bound_decoder_chk.sv
// Module row_bound_decoder_chk
// Property checker. It builds its own copy of the boundaries from the write
// port and snapshots it at each lookup, then checks every response against it.
// Assumes: bound to row_bound_decoder with matching parameters.
module row_bound_decoder_chk #(
    parameter int NUM_ROWS    = 8,
    parameter int BND_W       = 7,
    parameter int GRAIN_SHIFT = 26,
    parameter int ADDR_W      = BND_W + GRAIN_SHIFT,
    parameter int IDX_W       = $clog2(NUM_ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_sel,
    input logic [BND_W:0]    cfg_wdata,
    input logic              dual_mode,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [IDX_W-1:0]  rsp_row,
    input logic              rsp_hit,
    input logic              rsp_oor
);

    localparam logic [IDX_W:0] HALF_ROWS = (IDX_W+1)'(NUM_ROWS / 2);

    logic [BND_W-1:0] shadow [NUM_ROWS];
    logic [BND_W-1:0] snap   [NUM_ROWS];
    logic [BND_W-1:0] blk_d;
    logic             dual_d;
    logic [BND_W-1:0] lo_d;
    logic [BND_W-1:0] hi_d;
    logic [BND_W-1:0] tot_d;
    logic             unused_chk;

    assign unused_chk = ^{cfg_wdata[BND_W], req_addr[GRAIN_SHIFT-1:0]};

    // Purpose: mirror boundary writes and snapshot them with each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ROWS; i++) begin
                shadow[i] <= '0;
                snap[i]   <= '0;
            end
            blk_d  <= '0;
            dual_d <= 1'b0;
        end else begin
            if (cfg_we) begin
                shadow[cfg_sel] <= cfg_wdata[BND_W-1:0];
            end
            if (req_valid) begin
                for (int i = 0; i < NUM_ROWS; i++) begin
                    snap[i] <= shadow[i];
                end
                blk_d  <= req_addr[ADDR_W-1:GRAIN_SHIFT];
                dual_d <= dual_mode;
            end
        end
    end

    // Purpose: window of the reported row and the active total, from the snapshot.
    always_comb begin
        lo_d  = (rsp_row == '0) ? '0 : snap[rsp_row - 1'b1];
        hi_d  = snap[rsp_row];
        tot_d = dual_d ? snap[NUM_ROWS/2 - 1] : snap[NUM_ROWS - 1];
    end

    a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_row) && $stable(rsp_hit) && $stable(rsp_oor)));

    a_r3_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ((blk_d >= lo_d) && (blk_d < hi_d)));

    a_r4_hit_row_populated: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (hi_d != lo_d));

    a_r5_oor_matches_total: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_oor == (blk_d >= tot_d)));

    a_r5_oor_clears_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> (!rsp_hit && (rsp_row == '0)));

    a_r7_dual_lower_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && dual_d) |-> ({1'b0, rsp_row} < HALF_ROWS));

endmodule

bind row_bound_decoder row_bound_decoder_chk #(
    .NUM_ROWS    (NUM_ROWS),
    .BND_W       (BND_W),
    .GRAIN_SHIFT (GRAIN_SHIFT),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W)
) u_chk (.*);

// File: tb/row_bound_decoder_tb_top.sv
`timescale 1ns/1ps
module row_bound_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        dual_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [32:0] req_addr = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_row;
    logic        rsp_hit;
    logic        rsp_oor;

    int checks = 0;
    int errors = 0;
    logic [6:0] bnd_m [8];

    always #5 clk = ~clk;

    row_bound_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .dual_mode (dual_mode),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_row   (rsp_row),
        .rsp_hit   (rsp_hit),
        .rsp_oor   (rsp_oor)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,row,hit,oor} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Expected {row,hit,oor} from the requirements' arithmetic
    function automatic logic [4:0] model(input logic [6:0] q, input logic dual);
        int n;
        logic [6:0] lo;
        logic [2:0] row = '0;
        logic hit = 1'b0;
        logic oor;
        n = dual ? 4 : 8;
        oor = (q >= bnd_m[n-1]);
        if (!oor) begin
            for (int i = n - 1; i >= 0; i--) begin
                lo = (i == 0) ? 7'd0 : bnd_m[i-1];
                if (q >= lo && q < bnd_m[i]) begin
                    row = 3'(i);
                    hit = 1'b1;
                end
            end
        end
        return {row, hit, oor};
    endfunction

    task automatic write_bnd(input int idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'(idx);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
        bnd_m[idx] = data[6:0];
    endtask

    task automatic lookup(input logic [32:0] addr, input logic dual);
        req_valid = 1'b1;
        req_addr  = addr;
        dual_mode = dual;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sweep(input logic dual, input string tag);
        for (int q = 0; q < 128; q++) begin
            for (int p = 0; p < 2; p++) begin
                lookup({7'(q), (p == 0) ? 26'h0 : 26'h3FF_FFFF}, dual);
                check(tag, {rsp_valid, rsp_row, rsp_hit, rsp_oor}, {1'b1, model(7'(q), dual)});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) bnd_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1 reset outputs", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b0);
        // R1: empty map puts every address out of range
        @(negedge clk);
        lookup(33'h1_2345_6789, 1'b0);
        check("R1 empty map", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_000_0_1);

        // Monotonic map with empty rows 1 and 4; R2 reserved bit set on some writes
        write_bnd(0, 8'h84);
        write_bnd(1, 8'h04);
        write_bnd(2, 8'h8A);
        write_bnd(3, 8'd20);
        write_bnd(4, 8'd20);
        write_bnd(5, 8'd33);
        write_bnd(6, 8'hBC);
        write_bnd(7, 8'd100);
        // R2: reserved bit dropped, so block 3 is row 0 and block 4 is row 2
        lookup({7'd3, 26'h0}, 1'b0);
        check("R2 bit7 ignored lo", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_000_1_0);
        lookup({7'd4, 26'h0}, 1'b0);
        check("R2 bit7 ignored hi", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_010_1_0);
        // R3 R4 R5 R9 single-channel sweep
        sweep(1'b0, "R3 R4 R5 R9 single sweep");
        // R7 dual: rows 4..7 hold values yet limit is row 3 (20)
        sweep(1'b1, "R7 R5 dual sweep");
        lookup({7'd25, 26'h0}, 1'b1);
        check("R7 upper rows ignored", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_000_0_1);

        // R8: response holds while idle
        lookup({7'd50, 26'h0}, 1'b0);
        check("R8 response", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_110_1_0);
        req_addr = {7'd1, 26'h0};
        @(negedge clk);
        check("R8 idle hold", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b0_110_1_0);

        // R6 overlapping map: row0 [0,10), row2 [2,8) overlaps; lowest wins
        write_bnd(0, 8'd10);
        write_bnd(1, 8'd2);
        write_bnd(2, 8'd8);
        lookup({7'd5, 26'h155_5555}, 1'b0);
        check("R6 lowest index wins", {rsp_valid, rsp_row, rsp_hit, rsp_oor}, 6'b1_000_1_0);
        sweep(1'b0, "R6 R4 overlap sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule